// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the pin-level timing of a multiplexed external memory bus for an 8-bit microcontroller core. A machine cycle lasts either 12 or 6 clocks, selected by a static mode input. Each machine cycle carries one bus operation, chosen one cycle in advance: a code fetch, a data access through a 16-bit pointer, a data access through an 8-bit register pointer, or no access. The block drives the address latch enable pulse, a shared port that carries the low address byte and then data, a port for the high address byte, and active-low read and write strobes.

One port carries the low address byte first and the data after it. An external latch captures the address byte on the falling edge of the latch enable. In non-data cycles the latch enable pulses once in each half of the machine cycle. In a data cycle only the first of those pulses appears. A mute control suppresses the pulse in every cycle except data cycles. For register-pointer accesses and idle cycles, the high port shows the port latch value instead of an address byte. Read data is captured when the read strobe is released.

The request, the mute control and the port latch value are taken together as a snapshot once per machine cycle. That snapshot fixes the behaviour of the whole following cycle. A one-clock `mcyc` pulse marks the first slot of every machine cycle.

Top module: `xmem_bus_seq`

## Requirements
- R1: While `rst` is high and in the clock after it, `ale`=0, `p0_oe`=0, `rd_n`=1, `wr_n`=1, `rdata_valid`=0, `mcyc`=0 and `p2_out`=8'hFF. The first machine cycle after reset is an idle cycle with mute clear.
- R2: A machine cycle lasts N slots of one clock each: N=12 with `short_mode`=0, or N=6 with `short_mode`=1. `mcyc` is high only in slot 0. Below, H=N/2 and A=H/3.
- R3: In fetch and idle cycles with mute clear, `ale` is high in slots 0..A-1 and H..H+A-1 and low in every other slot.
- R4: In a data cycle (`req_kind` 2'b01 for the 16-bit pointer, 2'b10 for the register pointer), `ale` is high only in slots 0..A-1. The pulse in the second half is omitted.
- R5: With mute set, `ale` stays low for the whole of a fetch or idle cycle. Data cycles keep their single pulse.
- R6: In slots 0..2A-1 of a data cycle, `p0_oe`=1 and `p0_out`=addr[7:0]. A fetch (`req_kind` 2'b00) drives addr[7:0] in slots 0..2A-1 and (addr+1)[7:0] in slots H..H+2A-1, and leaves `p0_oe`=0 in its other slots.
- R7: In a data write (`req_write`=1), `p0_oe`=1 and `p0_out` equals the write byte in slots 2A..N-1, and `wr_n`=0 exactly in slots H..N-2.
- R8: In a data read, `p0_oe`=0 in slots 2A..N-1 and `rd_n`=0 exactly in slots H..N-2. `rdata` takes the value on `p0_in` at the end of slot N-2, and `rdata_valid` is high in slot N-1 only.
- R9: In a fetch, `p2_out` is the high byte of the address on P0 (addr, then addr+1). In a 16-bit pointer access it is addr[15:8]. In register-pointer and idle cycles it is the sampled port latch value.
- R10: `rd_n` and `wr_n` are never low together, and neither is low while `ale` is high.
- R11: All request inputs, `ale_mute` and `p2_latch` are sampled once per machine cycle, at the end of slot N-2, for the following cycle. If `req_valid`=0 or `req_kind`=2'b11, the following cycle is idle: `p0_oe`=0 and both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| short_mode | input | 1 | Static cycle length select: 1 = 6 clocks, 0 = 12 clocks |
| req_valid | input | 1 | A bus operation is requested for the next cycle |
| req_kind | input | 2 | 00 fetch, 01 16-bit pointer data, 10 register-pointer data, 11 none |
| req_addr | input | 16 | Operation address |
| req_wdata | input | 8 | Write byte for data writes |
| req_write | input | 1 | 1 = data write, 0 = data read |
| ale_mute | input | 1 | Suppress the latch enable outside data cycles |
| p2_latch | input | 8 | High port latch value |
| p0_in | input | 8 | Value seen on the shared port pins |
| ale | output | 1 | Address latch enable |
| p0_out | output | 8 | Shared port drive value |
| p0_oe | output | 1 | Shared port output enable |
| p2_out | output | 8 | High port drive value |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rdata | output | 8 | Captured read byte |
| rdata_valid | output | 1 | Read byte updated this slot |
| mcyc | output | 1 | Slot 0 marker of each machine cycle |

## Verification
The hardest case to reach is a read in 6-clock mode. There the strobe is low for only two slots, and the byte must be captured in the clock where the strobe rises while the shared port is released. A pointer-based write or read must also fall between fetches whose address increment crosses a high-byte boundary. The driver waits for each `mcyc`, drives the request for the next cycle and queues the expected cycle. The monitor places the read byte on `p0_in` at slot 0 of that cycle and compares every slot. The whole sequence, including the reserved kind code and the muted cycles, runs once per cycle length, with a reset between the two runs.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
  parameter int XBS_AW = 16;
  parameter int XBS_DW = 8;
  localparam int XBS_HW = XBS_AW - XBS_DW;

  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_DPTR  = 2'b01,
    K_INDIR = 2'b10,
    K_IDLE  = 2'b11
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic               wr;
    logic               mute;
    logic [XBS_AW-1:0]  addr;
    logic [XBS_DW-1:0]  wd;
    logic [XBS_HW-1:0]  p2l;
  } cyc_rec_t;

  typedef struct packed {
    logic               ale;
    logic               p0_oe;
    logic [XBS_DW-1:0]  p0;
    logic [XBS_HW-1:0]  p2;
    logic               rd_n;
    logic               wr_n;
  } pins_t;
endpackage

// File: rtl/xbs_phase_gen.sv
module xbs_phase_gen #(
  parameter int CYC_LONG  = 12,
  parameter int CYC_SHORT = 6,
  localparam int PW = $clog2(CYC_LONG + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          short_mode,
  output logic [PW-1:0] ph,
  output logic          ph_last
);
  logic [PW-1:0] n_m1;

  always_comb begin
    n_m1    = short_mode ? PW'(CYC_SHORT - 1) : PW'(CYC_LONG - 1);
    ph_last = (ph == n_m1);
  end

  always_ff @(posedge clk) begin
    if (rst)          ph <= '0;
    else if (ph_last) ph <= '0;
    else              ph <= ph + 1'b1;
  end

  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph <= n_m1);
endmodule

// File: rtl/xbs_slot_decode.sv
module xbs_slot_decode
  import xbs_pkg::*;
#(
  parameter int CYC_LONG  = 12,
  parameter int CYC_SHORT = 6,
  localparam int PW = $clog2(CYC_LONG + 1)
) (
  input  logic [PW-1:0] ph,
  input  logic          short_mode,
  input  cyc_rec_t      rec,
  output pins_t         pins
);
  logic [PW-1:0]     n_m2, h, a, a2, pos;
  logic              half, is_data;
  logic [XBS_AW-1:0] fa;

  always_comb begin
    h    = short_mode ? PW'(CYC_SHORT / 2)     : PW'(CYC_LONG / 2);
    a    = short_mode ? PW'(CYC_SHORT / 6)     : PW'(CYC_LONG / 6);
    a2   = short_mode ? PW'(2 * (CYC_SHORT / 6)) : PW'(2 * (CYC_LONG / 6));
    n_m2 = short_mode ? PW'(CYC_SHORT - 2)     : PW'(CYC_LONG - 2);
    half = (ph >= h);
    pos  = half ? (ph - h) : ph;
    is_data = (rec.kind == K_DPTR) || (rec.kind == K_INDIR);
    fa   = rec.addr + XBS_AW'(half);

    pins       = '0;
    pins.rd_n  = 1'b1;
    pins.wr_n  = 1'b1;
    pins.p2    = rec.p2l;

    unique case (rec.kind)
      K_FETCH: begin
        pins.ale = !rec.mute && (pos < a);
        if (pos < a2) begin
          pins.p0_oe = 1'b1;
          pins.p0    = fa[XBS_DW-1:0];
        end
        pins.p2 = fa[XBS_AW-1:XBS_DW];
      end
      K_DPTR, K_INDIR: begin
        pins.ale = !half && (pos < a);
        if (ph < a2) begin
          pins.p0_oe = 1'b1;
          pins.p0    = rec.addr[XBS_DW-1:0];
        end else if (rec.wr) begin
          pins.p0_oe = 1'b1;
          pins.p0    = rec.wd;
        end
        if (half && (ph <= n_m2)) begin
          pins.wr_n = !rec.wr;
          pins.rd_n = rec.wr;
        end
        if (rec.kind == K_DPTR) pins.p2 = rec.addr[XBS_AW-1:XBS_DW];
      end
      default: begin
        pins.ale = !rec.mute && (pos < a);
      end
    endcase
    if (!is_data) begin
      pins.rd_n = 1'b1;
      pins.wr_n = 1'b1;
    end
  end
endmodule

// File: rtl/xbs_rd_capture.sv
module xbs_rd_capture
  import xbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n_now,
  input  logic              rd_n_next,
  input  logic [XBS_DW-1:0] p0_in,
  output logic [XBS_DW-1:0] rdata,
  output logic              rdata_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      rdata_valid <= !rd_n_now && rd_n_next;
      if (!rd_n_now && rd_n_next) rdata <= p0_in;
    end
  end

  // R8
  rvalid_src_chk: assert property (@(posedge clk) disable iff (rst)
    rdata_valid |-> ($past(rd_n_now) == 1'b0 && rd_n_now));
endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
  import xbs_pkg::*;
#(
  parameter int CYC_LONG  = 12,
  parameter int CYC_SHORT = 6,
  localparam int PW = $clog2(CYC_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              short_mode,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [XBS_AW-1:0] req_addr,
  input  logic [XBS_DW-1:0] req_wdata,
  input  logic              req_write,
  input  logic              ale_mute,
  input  logic [XBS_HW-1:0] p2_latch,
  input  logic [XBS_DW-1:0] p0_in,
  output logic              ale,
  output logic [XBS_DW-1:0] p0_out,
  output logic              p0_oe,
  output logic [XBS_HW-1:0] p2_out,
  output logic              rd_n,
  output logic              wr_n,
  output logic [XBS_DW-1:0] rdata,
  output logic              rdata_valid,
  output logic              mcyc
);
  logic [PW-1:0] ph;
  logic          ph_last;
  cyc_rec_t      rec_q;
  pins_t         dec, pins_q;
  logic          mcyc_q;
  logic [2:0]    ale_rises;
  logic          ale_rise;

  xbs_phase_gen #(.CYC_LONG(CYC_LONG), .CYC_SHORT(CYC_SHORT)) u_phase (
    .clk(clk), .rst(rst), .short_mode(short_mode), .ph(ph), .ph_last(ph_last)
  );

  // Snapshot of the next machine cycle, taken in its predecessor's last phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_q      <= '0;
      rec_q.kind <= K_IDLE;
      rec_q.p2l  <= '1;
    end else if (ph_last) begin
      rec_q.kind <= req_valid ? kind_e'(req_kind) : K_IDLE;
      rec_q.wr   <= req_write;
      rec_q.mute <= ale_mute;
      rec_q.addr <= req_addr;
      rec_q.wd   <= req_wdata;
      rec_q.p2l  <= p2_latch;
    end
  end

  xbs_slot_decode #(.CYC_LONG(CYC_LONG), .CYC_SHORT(CYC_SHORT)) u_dec (
    .ph(ph), .short_mode(short_mode), .rec(rec_q), .pins(dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q      <= '0;
      pins_q.p2   <= '1;
      pins_q.rd_n <= 1'b1;
      pins_q.wr_n <= 1'b1;
      mcyc_q      <= 1'b0;
    end else begin
      pins_q <= dec;
      mcyc_q <= (ph == '0);
    end
  end

  xbs_rd_capture u_cap (
    .clk(clk), .rst(rst), .rd_n_now(pins_q.rd_n), .rd_n_next(dec.rd_n),
    .p0_in(p0_in), .rdata(rdata), .rdata_valid(rdata_valid)
  );

  assign ale    = pins_q.ale;
  assign p0_out = pins_q.p0;
  assign p0_oe  = pins_q.p0_oe;
  assign p2_out = pins_q.p2;
  assign rd_n   = pins_q.rd_n;
  assign wr_n   = pins_q.wr_n;
  assign mcyc   = mcyc_q;

  // Rising edges of the latch enable within the current machine cycle.
  assign ale_rise = dec.ale && !pins_q.ale;
  always_ff @(posedge clk) begin
    if (rst)             ale_rises <= '0;
    else if (ph == '0)   ale_rises <= {2'b00, ale_rise};
    else                 ale_rises <= ale_rises + {2'b00, ale_rise};
  end

  // R3
  ale_twice_chk: assert property (@(posedge clk) disable iff (rst)
    ale_rises <= 3'd2);
  // R5
  ale_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (ale && rec_q.mute) |-> (rec_q.kind == K_DPTR || rec_q.kind == K_INDIR));
  // R10
  rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  // R10
  strobe_ale_chk: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n));
  // R8
  rd_float_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !p0_oe);
  // R7
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> p0_oe);
  // R2
  mcyc_gap_chk: assert property (@(posedge clk) disable iff (rst)
    mcyc |=> !mcyc);
endmodule

// File: tb/sim_xmem_bus_seq.sv
module sim_xmem_bus_seq;
  typedef struct {
    bit         valid;
    logic [1:0] kind;
    bit         wr;
    bit         mute;
    logic [15:0] addr;
    logic [7:0] wd;
    logic [7:0] p2l;
    logic [7:0] rb;
  } cyc_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic short_mode = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b11;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_write = 1'b0;
  logic ale_mute = 1'b0;
  logic [7:0] p2_latch = 8'hFF;
  logic [7:0] p0_in = '0;
  logic ale, p0_oe, rd_n, wr_n, rdata_valid, mcyc;
  logic [7:0] p0_out, p2_out, rdata;

  int checks = 0;
  int errors = 0;
  cyc_t q[$];
  bit timeout = 1'b0;

  always #2 clk = ~clk;

  xmem_bus_seq u0 (
    .clk(clk), .rst(rst), .short_mode(short_mode), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_write(req_write), .ale_mute(ale_mute), .p2_latch(p2_latch),
    .p0_in(p0_in), .ale(ale), .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata), .rdata_valid(rdata_valid),
    .mcyc(mcyc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic cyc_t idle_rec();
    cyc_t c;
    c.valid = 0; c.kind = 2'b11; c.wr = 0; c.mute = 0;
    c.addr = '0; c.wd = '0; c.p2l = 8'hFF; c.rb = '0;
    return c;
  endfunction

  // Monitor: pops one expected cycle at each slot-0 marker and checks every slot.
  cyc_t cur;
  int   slot = 0;
  bit   active = 0;
  always @(negedge clk) begin
    if (rst) begin
      active = 0;
      slot = 0;
    end else begin
      int n, h, a, k;
      bit data, exp_ale, exp_oe, exp_rd, exp_wr, exp_rv;
      logic [15:0] fa;
      logic [7:0] exp_p0, exp_p2;
      string at;
      n = short_mode ? 6 : 12;
      h = n / 2;
      a = h / 3;
      if (mcyc) begin
        if (active) chk(slot + 1 == n, "R2", "cycle length", slot + 1, n);
        cur = (q.size() > 0) ? q.pop_front() : idle_rec();
        slot = 0;
        active = 1;
        p0_in = cur.rb;
      end else if (active) begin
        slot++;
      end
      if (active) begin
        k = cur.valid ? int'(cur.kind) : 3;
        data = (k == 1) || (k == 2);
        fa = cur.addr + ((slot >= h) ? 16'd1 : 16'd0);
        exp_ale = 0; exp_oe = 0; exp_p0 = '0; exp_rd = 1; exp_wr = 1; exp_rv = 0;
        exp_p2 = cur.p2l;
        if (k == 0) begin
          exp_ale = !cur.mute && ((slot < a) || (slot >= h && slot < h + a));
          exp_oe = (slot < 2 * a) || (slot >= h && slot < h + 2 * a);
          exp_p0 = fa[7:0];
          exp_p2 = fa[15:8];
        end else if (data) begin
          exp_ale = slot < a;
          exp_oe = (slot < 2 * a) || cur.wr;
          exp_p0 = (slot < 2 * a) ? cur.addr[7:0] : cur.wd;
          if (k == 1) exp_p2 = cur.addr[15:8];
          exp_wr = !(cur.wr && slot >= h && slot <= n - 2);
          exp_rd = !(!cur.wr && slot >= h && slot <= n - 2);
          exp_rv = !cur.wr && (slot == n - 1);
        end else begin
          exp_ale = !cur.mute && ((slot < a) || (slot >= h && slot < h + a));
        end
        at = $sformatf("kind %0d slot %0d", k, slot);
        chk(ale === exp_ale, data ? "R4" : (cur.mute ? "R5" : "R3"),
            {"ale ", at}, ale, exp_ale);
        chk(p0_oe === exp_oe, (k == 3) ? "R11" : (slot < 2 * a || k == 0) ? "R6" :
            (cur.wr ? "R7" : "R8"), {"p0_oe ", at}, p0_oe, exp_oe);
        if (exp_oe)
          chk(p0_out === exp_p0, (slot < 2 * a || k == 0) ? "R6" : "R7",
              {"p0_out ", at}, p0_out, exp_p0);
        chk(p2_out === exp_p2, "R9", {"p2_out ", at}, p2_out, exp_p2);
        chk(wr_n === exp_wr, (k == 3) ? "R11" : "R7", {"wr_n ", at}, wr_n, exp_wr);
        chk(rd_n === exp_rd, (k == 3) ? "R11" : "R8", {"rd_n ", at}, rd_n, exp_rd);
        chk(rdata_valid === exp_rv, "R8", {"rdata_valid ", at}, rdata_valid, exp_rv);
        if (exp_rv) chk(rdata === cur.rb, "R8", {"rdata ", at}, rdata, cur.rb);
        chk(!(ale && (!rd_n || !wr_n)) && !(!rd_n && !wr_n), "R10",
            {"strobe overlap ", at}, {ale, rd_n, wr_n}, 3'b011);
      end
    end
  end

  // Driver: request for the next machine cycle, pushed as the expected item.
  task automatic issue(input bit v, input logic [1:0] k, input logic [15:0] ad,
                       input logic [7:0] wd, input bit w, input bit m,
                       input logic [7:0] p2l, input logic [7:0] rb);
    cyc_t c;
    do @(negedge clk); while (!mcyc);
    #1;
    req_valid = v; req_kind = k; req_addr = ad; req_wdata = wd;
    req_write = w; ale_mute = m; p2_latch = p2l;
    c.valid = v; c.kind = k; c.wr = w; c.mute = m;
    c.addr = ad; c.wd = wd; c.p2l = p2l; c.rb = rb;
    q.push_back(c);
  endtask

  task automatic do_reset(input bit sm);
    @(negedge clk);
    rst = 1'b1;
    short_mode = sm;
    req_valid = 0; req_kind = 2'b11; ale_mute = 0; p2_latch = 8'hFF;
    q.delete();
    repeat (3) @(negedge clk);
    // R1
    chk(ale === 0 && p0_oe === 0 && rd_n === 1 && wr_n === 1 &&
        rdata_valid === 0 && mcyc === 0 && p2_out === 8'hFF, "R1", "reset outputs",
        {ale, p0_oe, rd_n, wr_n, rdata_valid, mcyc, p2_out}, {6'b001100, 8'hFF});
    rst = 1'b0;
  endtask

  task automatic run_seq();
    issue(0, 2'b00, 16'h0000, 8'h00, 0, 0, 8'hFF, 8'h00);  // R11 idle
    issue(1, 2'b00, 16'h12FF, 8'h00, 0, 0, 8'h11, 8'h00);  // R6 fetch crossing
    issue(1, 2'b01, 16'hA5C3, 8'h5A, 1, 0, 8'h22, 8'h00);  // R7 pointer write
    issue(1, 2'b01, 16'h8001, 8'h00, 0, 0, 8'h33, 8'h3C);  // R8 pointer read
    issue(1, 2'b10, 16'h0044, 8'h96, 1, 0, 8'h7E, 8'h00);  // R9 reg write
    issue(1, 2'b10, 16'hBB12, 8'h00, 0, 0, 8'h81, 8'hE7);  // R9 reg read
    issue(0, 2'b01, 16'h4321, 8'h00, 1, 1, 8'h55, 8'h00);  // R5 muted idle
    issue(1, 2'b00, 16'h0200, 8'h00, 0, 1, 8'h66, 8'h00);  // R5 muted fetch
    issue(1, 2'b01, 16'hFFFE, 8'h00, 0, 1, 8'h77, 8'hA1);  // R5 muted read
    issue(1, 2'b11, 16'h1234, 8'hC3, 1, 0, 8'h44, 8'h00);  // R11 reserved code
    issue(1, 2'b00, 16'hFFFF, 8'h00, 0, 0, 8'h99, 8'h00);  // R6 wrap
    issue(0, 2'b11, 16'h0000, 8'h00, 0, 0, 8'hFF, 8'h00);
    repeat (3) begin
      do @(negedge clk); while (!mcyc);
    end
  endtask

  initial begin
    fork
      begin
        do_reset(1'b0);
        run_seq();
        do_reset(1'b1);
        run_seq();
      end
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    disable fork;
    if (timeout) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule